// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block stores a small array of words and finds them by their contents rather than by their position. A caller offers a search pattern together with a column mask. Every stored word is compared against the pattern at the same time, in the columns whose mask bit is 1. Columns whose mask bit is 0 take no part in the comparison. The result is a vector with one bit per word, registered one clock after the request is taken. Alongside the vector come a hit flag, the index of the lowest matching word and that word's contents.

Words are loaded one at a time through a plain write port that names a slot. Loading a slot marks it valid, and a slot that has never been written can never match. Searches enter on a valid/ready stream and results leave on a valid/ready stream. A search is taken only in a cycle where the result register is empty, or where its current result is being taken in that same cycle. While a result waits with `res_ready` low, the result stays frozen and `srch_ready` is held low.

Top module: `masked_cam`

## Requirements
- R1: After reset `res_valid` is 0, `srch_ready` is 1, and no slot is valid, so a search with an all-zero mask reports no hit.
- R2: A search is taken at a rising edge where `srch_valid` and `srch_ready` are both 1. Its result is presented with `res_valid` 1 directly after that edge, one clock later.
- R3: Bit i of `res_match` (bit 0 = slot 0) is 1 exactly when slot i is valid and, for every column j whose `srch_mask[j]` is 1, stored bit j equals `srch_pattern[j]`.
- R4: A column whose mask bit is 0 is ignored for every slot. With an all-zero mask, every valid slot matches.
- R5: A slot that has not been written since reset never sets its match bit, whatever the pattern and mask.
- R6: `res_hit` is 1 exactly when any bit of `res_match` is 1. On a hit, `res_idx` is the lowest set bit position of `res_match` and `res_data` is that slot's contents. On a miss, both `res_idx` and `res_data` are 0.
- R7: With `wr_en` high at an edge, slot `wr_idx` takes the value `wr_data` and becomes valid. A search taken at that same edge is compared against the contents as they were before the write.
- R8: While `res_valid` is 1 and `res_ready` is 0, `srch_ready` is 0 and all result outputs hold their values.
- R9: A result is taken at an edge where `res_valid` and `res_ready` are both 1. If no new search is taken at that edge, `res_valid` is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one slot this cycle |
| wr_idx | input | IDXW | Slot to load |
| wr_data | input | WIDTH | Word to store |
| srch_valid | input | 1 | Search request offered |
| srch_ready | output | 1 | Search request can be taken |
| srch_pattern | input | WIDTH | Pattern to compare against |
| srch_mask | input | WIDTH | 1 = column compared, 0 = column ignored |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_match | output | WORDS | One match bit per slot |
| res_hit | output | 1 | Any slot matched |
| res_idx | output | IDXW | Lowest matching slot |
| res_data | output | WIDTH | Contents of the lowest matching slot |

## Verification
The properties check the stream rules on every cycle: a taken search yields a result on the next edge, a stalled result holds still, and a taken result with no new search empties the register. They also check that the hit flag, the lowest index and the zeroed miss outputs agree with the match vector. Whether each match bit is correct for the stored contents can only be shown by the scenarios. These cover masked and unmasked columns, slots that were never written, duplicate contents, and a write that coincides with a search. A reference model in the bench predicts every result.

// File: rtl/masked_cam_pkg.sv
package masked_cam_pkg;

  localparam int DEF_WORDS = 8;
  localparam int DEF_WIDTH = 16;

  // Width of a slot index; at least one bit so ports never collapse.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cam_word.sv
module cam_word #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic [WIDTH-1:0] pattern,
  input  logic [WIDTH-1:0] care,
  output logic [WIDTH-1:0] word_q,
  output logic             match
);

  logic             valid_q;
  logic [WIDTH-1:0] agree;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      word_q  <= load_data;
    end
  end

  // Per-column cell: equal bits agree, and a column outside the mask always agrees.
  for (genvar j = 0; j < WIDTH; j++) begin : g_cell
    assign agree[j] = (pattern[j] & word_q[j]) | (~pattern[j] & ~word_q[j]) | ~care[j];
  end

  assign match = valid_q & (&agree);

endmodule

// File: rtl/cam_first_match.sv
module cam_first_match #(
  parameter int WORDS = 8,
  parameter int IDXW  = 3
) (
  input  logic [WORDS-1:0] vec,
  output logic             found,
  output logic [IDXW-1:0]  first
);

  always_comb begin
    first = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (vec[i]) first = IDXW'(i);
    end
  end

  assign found = |vec;

endmodule

// File: rtl/masked_cam.sv
module masked_cam
  import masked_cam_pkg::*;
#(
  parameter int  WORDS = DEF_WORDS,
  parameter int  WIDTH = DEF_WIDTH,
  localparam int IDXW  = idx_bits(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             srch_valid,
  output logic             srch_ready,
  input  logic [WIDTH-1:0] srch_pattern,
  input  logic [WIDTH-1:0] srch_mask,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [WORDS-1:0] res_match,
  output logic             res_hit,
  output logic [IDXW-1:0]  res_idx,
  output logic [WIDTH-1:0] res_data
);

  logic [WIDTH-1:0] slot_q [WORDS];
  logic [WORDS-1:0] raw_match;
  logic             any_hit;
  logic [IDXW-1:0]  low_idx;
  logic             take;

  for (genvar i = 0; i < WORDS; i++) begin : g_slot
    cam_word #(.WIDTH(WIDTH)) u_word (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_en && (wr_idx == IDXW'(i))),
      .load_data (wr_data),
      .pattern   (srch_pattern),
      .care      (srch_mask),
      .word_q    (slot_q[i]),
      .match     (raw_match[i])
    );
  end

  cam_first_match #(.WORDS(WORDS), .IDXW(IDXW)) u_first (
    .vec   (raw_match),
    .found (any_hit),
    .first (low_idx)
  );

  assign srch_ready = !res_valid || res_ready;
  assign take       = srch_valid && srch_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_match <= '0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_data  <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_match <= raw_match;
      res_hit   <= any_hit;
      res_idx   <= any_hit ? low_idx : '0;
      res_data  <= any_hit ? slot_q[low_idx] : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/masked_cam_chk.sv
module masked_cam_chk #(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  parameter int IDXW  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             srch_valid,
  input logic             srch_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [WORDS-1:0] res_match,
  input logic             res_hit,
  input logic [IDXW-1:0]  res_idx,
  input logic [WIDTH-1:0] res_data
);

  logic [WORDS-1:0] below;
  assign below = ({{(WORDS-1){1'b0}}, 1'b1} << res_idx) - 1'b1;

  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    srch_valid && srch_ready |=> res_valid);

  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && !(srch_valid && srch_ready) |=> !res_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_match) && $stable(res_hit)
                                && $stable(res_idx) && $stable(res_data));

  a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !srch_ready);

  a_r6_hit_any: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_hit == (res_match != '0));

  a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> res_match[res_idx] && ((res_match & below) == '0));

  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_idx == '0 && res_data == '0);

endmodule

bind masked_cam masked_cam_chk #(.WORDS(WORDS), .WIDTH(WIDTH), .IDXW(IDXW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .srch_valid (srch_valid),
  .srch_ready (srch_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_match  (res_match),
  .res_hit    (res_hit),
  .res_idx    (res_idx),
  .res_data   (res_data)
);

// File: tb/masked_cam_bench.sv
module masked_cam_bench;

  localparam int WORDS = 8;
  localparam int WIDTH = 16;
  localparam int IDXW  = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [IDXW-1:0]  wr_idx = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             srch_valid = 1'b0;
  logic             srch_ready;
  logic [WIDTH-1:0] srch_pattern = '0;
  logic [WIDTH-1:0] srch_mask = '0;
  logic             res_valid;
  logic             res_ready = 1'b1;
  logic [WORDS-1:0] res_match;
  logic             res_hit;
  logic [IDXW-1:0]  res_idx;
  logic [WIDTH-1:0] res_data;

  always #4 clk = ~clk;

  masked_cam #(.WORDS(WORDS), .WIDTH(WIDTH)) u_masked_cam (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .srch_valid(srch_valid), .srch_ready(srch_ready), .srch_pattern(srch_pattern),
    .srch_mask(srch_mask), .res_valid(res_valid), .res_ready(res_ready),
    .res_match(res_match), .res_hit(res_hit), .res_idx(res_idx), .res_data(res_data)
  );

  typedef struct packed {
    logic [WORDS-1:0] m;
    logic             h;
    logic [IDXW-1:0]  i;
    logic [WIDTH-1:0] d;
  } exp_t;

  exp_t             sb_q[$];
  logic [WIDTH-1:0] mdl_d [WORDS];
  logic             mdl_v [WORDS];
  int               n_chk = 0;
  int               n_bad = 0;
  bit               done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [WIDTH-1:0] pat, input logic [WIDTH-1:0] msk);
    exp_t e;
    e = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (mdl_v[i] && (((mdl_d[i] ^ pat) & msk) == '0)) e.m[i] = 1'b1;
    end
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (e.m[i]) begin
        e.i = IDXW'(i);
        e.d = mdl_d[i];
      end
    end
    e.h = (e.m != '0);
    return e;
  endfunction

  // Monitor: a transfer happens at the next edge when both valid and ready are seen here.
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R2", "result with no pending search", 64'(res_match), 64'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(res_match == e.m, "R3", "match vector", 64'(res_match), 64'(e.m));
        chk(res_hit == e.h, "R6", "hit flag", 64'(res_hit), 64'(e.h));
        chk(res_idx == e.i, "R6", "lowest index", 64'(res_idx), 64'(e.i));
        chk(res_data == e.d, "R6", "read data", 64'(res_data), 64'(e.d));
      end
    end
  end

  task automatic wr(input int idx, input logic [WIDTH-1:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_idx = IDXW'(idx); wr_data = d;
    @(posedge clk);
    mdl_d[idx] = d; mdl_v[idx] = 1'b1;
    #1 wr_en = 1'b0;
  endtask

  task automatic search(input logic [WIDTH-1:0] pat, input logic [WIDTH-1:0] msk);
    @(posedge clk); #1;
    srch_valid = 1'b1; srch_pattern = pat; srch_mask = msk;
    forever begin
      @(negedge clk);
      if (srch_ready) break;
    end
    sb_q.push_back(predict(pat, msk));
    @(posedge clk); #1;
    srch_valid = 1'b0;
  endtask

  // Search and write offered at the same edge (R7): prediction uses the old model.
  task automatic search_with_write(input logic [WIDTH-1:0] pat, input logic [WIDTH-1:0] msk,
                                   input int idx, input logic [WIDTH-1:0] d);
    @(posedge clk); #1;
    srch_valid = 1'b1; srch_pattern = pat; srch_mask = msk;
    wr_en = 1'b1; wr_idx = IDXW'(idx); wr_data = d;
    @(negedge clk);
    chk(srch_ready == 1'b1, "R7", "ready for coincident search", 64'(srch_ready), 64'h1);
    sb_q.push_back(predict(pat, msk));
    @(posedge clk);
    mdl_d[idx] = d; mdl_v[idx] = 1'b1;
    #1 srch_valid = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [WORDS-1:0] snap_m;
    logic [WIDTH-1:0] snap_d;
    for (int i = 0; i < WORDS; i++) begin mdl_d[i] = '0; mdl_v[i] = 1'b0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(res_valid == 1'b0, "R1", "res_valid after reset", 64'(res_valid), 64'h0);
    chk(srch_ready == 1'b1, "R1", "srch_ready after reset", 64'(srch_ready), 64'h1);

    // R1, R5: empty array, all-zero mask must miss
    search('0, '0);
    @(negedge clk);
    // R2: result one clock after acceptance
    chk(res_valid == 1'b1, "R2", "result one clock after accept", 64'(res_valid), 64'h1);
    chk(res_hit == 1'b0, "R1", "no hit on empty array", 64'(res_hit), 64'h0);
    @(negedge clk);
    // R9: taken result with no new search empties the register
    chk(res_valid == 1'b0, "R9", "valid clears after take", 64'(res_valid), 64'h0);

    // R5: only slots 1 and 3 written; all-zero mask finds only them
    wr(1, 16'h1234);
    wr(3, 16'hABCD);
    search(16'hFFFF, '0);
    search(16'h1234, 16'hFFFF);

    for (int i = 0; i < WORDS; i++) begin
      if (i != 1 && i != 3) wr(i, 16'(16'h1000 * i + 16'h0055 * i + 16'h0001));
    end
    // R3: exact full-mask search
    search(16'(16'h5000 + 16'h0055 * 5 + 16'h0001), 16'hFFFF);
    // R6: duplicate contents, lowest index reported
    wr(2, 16'(16'h5000 + 16'h0055 * 5 + 16'h0001));
    search(16'(16'h5000 + 16'h0055 * 5 + 16'h0001), 16'hFFFF);
    // R4: only the top nibble compared
    search(16'hA000, 16'hF000);
    search(16'h0ABC, 16'h0000);
    search(16'h00CD, 16'h00FF);
    // R3: full-mask miss
    search(16'hDEAD, 16'hFFFF);

    // R7: overwrite slot 3 in the same cycle it is searched for
    search_with_write(16'hABCD, 16'hFFFF, 3, 16'h7777);
    search(16'hABCD, 16'hFFFF);
    search(16'h7777, 16'hFFFF);

    // R8: back-pressure holds the result and blocks new searches
    @(posedge clk); #1 res_ready = 1'b0;
    search(16'h7777, 16'hFFFF);
    @(negedge clk);
    snap_m = res_match; snap_d = res_data;
    chk(res_valid == 1'b1, "R8", "result waiting", 64'(res_valid), 64'h1);
    chk(srch_ready == 1'b0, "R8", "ready low while stalled", 64'(srch_ready), 64'h0);
    repeat (3) @(negedge clk);
    chk(res_match == snap_m, "R8", "match held", 64'(res_match), 64'(snap_m));
    chk(res_data == snap_d, "R8", "data held", 64'(res_data), 64'(snap_d));
    chk(srch_ready == 1'b0, "R8", "ready still low", 64'(srch_ready), 64'h0);
    @(posedge clk); #1 res_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R9", "valid clears after stalled take", 64'(res_valid), 64'h0);

    // Mixed traffic: patterns drawn from stored words under random masks (R3, R4)
    for (int k = 0; k < 150; k++) begin
      int s;
      logic [WIDTH-1:0] p;
      s = int'($urandom_range(0, WORDS - 1));
      p = (k % 3 == 0) ? 16'($urandom) : mdl_d[s];
      if (k % 10 == 0) wr(s, 16'($urandom) & 16'h0F0F);
      search(p, 16'($urandom) | ((k % 4 == 0) ? 16'h0000 : 16'h8001));
    end

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R2", "every search produced a result", 64'(sb_q.size()), 64'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule